// File: doc/BRIEF.md
# Preemptive Bus Arbiter

This block decides which of four masters drives a shared system bus: a memory refresh engine, a DMA engine, an external device that asks for the bus through a hold request, and the CPU. Each master raises a request line and drives the bus only while its acknowledge line is high. The arbiter picks a winner by fixed rank. DMA ranks above the external hold requester, which ranks above the CPU. The refresh engine has no fixed rank. It sits at the bottom while its request is new. It jumps to the top once it has waited through a set number of refresh interval ticks without being served.

Ownership is cooperative. When a master that outranks the current owner asks for the bus, the arbiter drops the owner's acknowledge and then waits. The new master is granted only after the owner takes its request away. Every handover passes through at least one cycle in which no acknowledge is high. With no competition, an owner keeps the bus for as long as it holds its request.

Top module: `bus_arbiter`

## Requirements
- R1: While rst_ni is low, all four acknowledge outputs are low, whatever the request inputs do.
- R2: At most one acknowledge output is high in any cycle.
- R3: From idle, a lone request is acknowledged at the first rising clock edge that samples it.
- R4: From idle with several requests, the grant goes to the highest ranked requester. Ranks run DMA, then external hold, then CPU, with non-urgent refresh below all three.
- R5: A non-urgent refresh request loses to any other request. It is granted when it is the only request.
- R6: A pending refresh request that is not being served counts the cycles in which ref_tick_i is high. Once URGENT_TICKS such ticks (default 2) have been counted, it outranks every other master, which preempts a DMA owner.
- R7: When a higher ranked master requests while another master owns the bus, the owner's acknowledge goes low at the next clock edge.
- R8: After a preemption, no acknowledge is given while the old owner keeps its request high. The new master is acknowledged at the second edge after the old owner drops its request.
- R9: An owner that is never outranked keeps its acknowledge for as long as its request stays high, with no time limit.
- R10: When the owner drops its request, its acknowledge falls at the next edge. The next grant comes no earlier than one edge later, so there is a cycle with no acknowledge between two owners.
- R11: With no request active, all acknowledges stay low.
- R12: A refresh owner that became urgent keeps its urgency until it drops its request, so a new DMA request does not preempt it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_req_i | input | 1 | Refresh engine bus request |
| ref_tick_i | input | 1 | One-cycle pulse marking each refresh interval |
| dma_req_i | input | 1 | DMA engine bus request |
| ext_hold_req_i | input | 1 | External hold request |
| cpu_req_i | input | 1 | CPU bus request |
| ref_ack_o | output | 1 | Bus granted to refresh engine |
| dma_ack_o | output | 1 | Bus granted to DMA engine |
| ext_hold_ack_o | output | 1 | Bus granted to external requester |
| cpu_ack_o | output | 1 | Bus granted to CPU |

## Verification
Directed patterns cover several cases:
- Simultaneous requests in different subsets from idle, which separate the fixed ranks from each other and show where non-urgent refresh falls in that order.
- A lower requester waiting beside a long-held grant, which shows that lower ranks do not preempt.
- A preemption in which the old owner holds its request for several cycles, which tells a correct handshake from an early grant.
- Refresh ticks delivered one at a time under a DMA owner, which pins the exact tick at which urgency starts.
- A DMA request made against an urgent refresh owner, which shows whether urgency survives the grant.

A seeded random phase then drives well-behaved requesters that release their request after a revocation or after a random hold time. On every new grant, it compares the granted master against the rank order applied to the requests seen in the cycle before.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  localparam int NUM_M   = 4;
  localparam int IDX_W   = $clog2(NUM_M);
  localparam int RANK_W  = 3;

  typedef enum logic [IDX_W-1:0] {
    M_REF  = 2'd0,
    M_DMA  = 2'd1,
    M_HOLD = 2'd2,
    M_CPU  = 2'd3
  } master_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_GRANT  = 2'd1,
    ST_REVOKE = 2'd2
  } arb_state_e;

  // lower value wins; refresh moves between top and bottom
  function automatic logic [RANK_W-1:0] rank_of(master_e m, logic urgent);
    case (m)
      M_REF:   rank_of = urgent ? 3'd0 : 3'd4;
      M_DMA:   rank_of = 3'd1;
      M_HOLD:  rank_of = 3'd2;
      default: rank_of = 3'd3;
    endcase
  endfunction
endpackage

// File: rtl/bus_arb_urgency.sv
module bus_arb_urgency #(
  parameter int URGENT_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic tick_i,
  input  logic serving_i,
  output logic urgent_o
);
  localparam int CNT_W = $clog2(URGENT_TICKS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(URGENT_TICKS);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!req_i) begin
      cnt_q <= '0;
    end else if (tick_i && !serving_i && cnt_q != LIMIT) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign urgent_o = (cnt_q == LIMIT);
endmodule

// File: rtl/bus_arb_rank.sv
module bus_arb_rank
  import bus_arb_pkg::*;
(
  input  logic [NUM_M-1:0] req_i,
  input  logic             urgent_i,
  input  logic [IDX_W-1:0] owner_i,
  output logic             win_valid_o,
  output logic [IDX_W-1:0] win_o,
  output logic             preempt_o
);
  logic [RANK_W-1:0] rank [NUM_M];

  for (genvar g = 0; g < NUM_M; g++) begin : g_rank
    assign rank[g] = rank_of(master_e'(IDX_W'(g)), urgent_i);
  end

  always_comb begin
    logic [RANK_W-1:0] best;
    best        = '1;
    win_valid_o = 1'b0;
    win_o       = '0;
    for (int m = 0; m < NUM_M; m++) begin
      if (req_i[m] && rank[m] < best) begin
        best        = rank[m];
        win_valid_o = 1'b1;
        win_o       = IDX_W'(m);
      end
    end
  end

  always_comb begin
    preempt_o = 1'b0;
    for (int m = 0; m < NUM_M; m++) begin
      if (req_i[m] && rank[m] < rank[owner_i]) preempt_o = 1'b1;
    end
  end
endmodule

// File: rtl/bus_arb_fsm.sv
module bus_arb_fsm
  import bus_arb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NUM_M-1:0] req_i,
  input  logic             win_valid_i,
  input  logic [IDX_W-1:0] win_i,
  input  logic             preempt_i,
  output logic [IDX_W-1:0] owner_o,
  output logic [NUM_M-1:0] ack_o
);
  arb_state_e       state_q, state_d;
  logic [IDX_W-1:0] owner_q, owner_d;

  always_comb begin
    state_d = state_q;
    owner_d = owner_q;
    case (state_q)
      ST_IDLE: begin
        if (win_valid_i) begin
          state_d = ST_GRANT;
          owner_d = win_i;
        end
      end
      ST_GRANT: begin
        if (!req_i[owner_q])  state_d = ST_IDLE;
        else if (preempt_i)   state_d = ST_REVOKE;
      end
      ST_REVOKE: begin
        // hold off the new master until the old one lets go
        if (!req_i[owner_q])  state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      owner_q <= '0;
    end else begin
      state_q <= state_d;
      owner_q <= owner_d;
    end
  end

  for (genvar g = 0; g < NUM_M; g++) begin : g_ack
    assign ack_o[g] = (state_q == ST_GRANT) && (owner_q == IDX_W'(g));
  end

  assign owner_o = owner_q;
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import bus_arb_pkg::*;
#(
  parameter int URGENT_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_req_i,
  input  logic ref_tick_i,
  input  logic dma_req_i,
  input  logic ext_hold_req_i,
  input  logic cpu_req_i,
  output logic ref_ack_o,
  output logic dma_ack_o,
  output logic ext_hold_ack_o,
  output logic cpu_ack_o
);
  logic [NUM_M-1:0] req_vec;
  logic [NUM_M-1:0] ack_vec;
  logic             ref_urgent;
  logic             win_valid;
  logic [IDX_W-1:0] win;
  logic [IDX_W-1:0] owner;
  logic             preempt;

  assign req_vec[M_REF]  = ref_req_i;
  assign req_vec[M_DMA]  = dma_req_i;
  assign req_vec[M_HOLD] = ext_hold_req_i;
  assign req_vec[M_CPU]  = cpu_req_i;

  bus_arb_urgency #(.URGENT_TICKS(URGENT_TICKS)) u_urg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (ref_req_i),
    .tick_i    (ref_tick_i),
    .serving_i (ack_vec[M_REF]),
    .urgent_o  (ref_urgent)
  );

  bus_arb_rank u_rank (
    .req_i       (req_vec),
    .urgent_i    (ref_urgent),
    .owner_i     (owner),
    .win_valid_o (win_valid),
    .win_o       (win),
    .preempt_o   (preempt)
  );

  bus_arb_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_vec),
    .win_valid_i (win_valid),
    .win_i       (win),
    .preempt_i   (preempt),
    .owner_o     (owner),
    .ack_o       (ack_vec)
  );

  assign ref_ack_o      = ack_vec[M_REF];
  assign dma_ack_o      = ack_vec[M_DMA];
  assign ext_hold_ack_o = ack_vec[M_HOLD];
  assign cpu_ack_o      = ack_vec[M_CPU];
endmodule

// File: rtl/bus_arbiter_chk.sv
module bus_arbiter_chk
  import bus_arb_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NUM_M-1:0] req_i,
  input logic [NUM_M-1:0] ack_i
);
  p_one_owner_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ack_i));

  for (genvar g = 0; g < NUM_M; g++) begin : g_m
    p_grant_needs_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ack_i[g]) |-> $past(req_i[g]));

    p_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[g] && !req_i[g]) |=> !ack_i[g]);

    p_gap_after_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(ack_i[g]) |-> (ack_i == '0));

    p_gap_before_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ack_i[g]) |-> ($past(ack_i) == '0));
  end
endmodule

bind bus_arbiter bus_arbiter_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req_i  (req_vec),
  .ack_i  (ack_vec)
);

// File: tb/bus_arbiter_tb_top.sv
`timescale 1ns/1ps
module bus_arbiter_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] rq = '0;   // bit0 ref, bit1 dma, bit2 hold, bit3 cpu
  logic       tick = 1'b0;
  logic [3:0] acks;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  bus_arbiter #(.URGENT_TICKS(2)) dut_i (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .ref_req_i      (rq[0]),
    .ref_tick_i     (tick),
    .dma_req_i      (rq[1]),
    .ext_hold_req_i (rq[2]),
    .cpu_req_i      (rq[3]),
    .ref_ack_o      (acks[0]),
    .dma_ack_o      (acks[1]),
    .ext_hold_ack_o (acks[2]),
    .cpu_ack_o      (acks[3])
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_ack(string tag, logic [3:0] exp);
    checks++;
    if (acks !== exp) begin
      errors++;
      $display("FAIL %s ack=%b expected=%b at %0t", tag, acks, exp, $time);
    end
  endtask

  // rank order with refresh not urgent: dma, hold, cpu, ref
  function automatic logic [3:0] best_of(logic [3:0] r);
    if (r[1]) return 4'b0010;
    if (r[2]) return 4'b0100;
    if (r[3]) return 4'b1000;
    if (r[0]) return 4'b0001;
    return 4'b0000;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] prev, a, rise;
    void'($urandom(32'h5eed));
    rq = 4'b1010;
    step(3);
    expect_ack("R1 reset", 4'b0000);
    rq = '0;
    rst_ni = 1'b1;
    step(3);
    expect_ack("R11 no requests", 4'b0000);

    rq = 4'b1000;
    step(1);
    expect_ack("R3 lone cpu", 4'b1000);
    rq[0] = 1'b1;
    step(40);
    expect_ack("R9 long hold", 4'b1000);
    rq[0] = 1'b0;
    step(1);

    rq[3] = 1'b0; rq[1] = 1'b1;
    step(1);
    expect_ack("R10 release gap", 4'b0000);
    step(1);
    expect_ack("R10 next grant", 4'b0010);
    rq = '0;
    step(3);
    expect_ack("R11 idle", 4'b0000);

    rq = 4'b1101;
    step(1);
    expect_ack("R4 hold over cpu", 4'b0100);
    rq = '0; step(3);
    rq = 4'b1110;
    step(1);
    expect_ack("R4 dma first", 4'b0010);
    rq = '0; step(3);
    rq = 4'b1001;
    step(1);
    expect_ack("R5 cpu over ref", 4'b1000);
    rq = '0; step(3);
    rq = 4'b0001;
    step(1);
    expect_ack("R5 ref alone", 4'b0001);
    rq = '0; step(3);

    rq = 4'b1000;
    step(1);
    expect_ack("R3 cpu owner", 4'b1000);
    rq[2] = 1'b1;
    step(1);
    expect_ack("R7 revoke", 4'b0000);
    step(5);
    expect_ack("R8 wait for release", 4'b0000);
    rq[3] = 1'b0;
    step(1);
    expect_ack("R8 gap", 4'b0000);
    step(1);
    expect_ack("R8 handover", 4'b0100);
    rq = '0; step(3);

    rq = 4'b0010;
    step(1);
    expect_ack("R4 dma owner", 4'b0010);
    rq[0] = 1'b1; tick = 1'b1;
    step(1);
    tick = 1'b0;
    step(4);
    expect_ack("R6 one tick", 4'b0010);
    tick = 1'b1;
    step(1);
    tick = 1'b0;
    step(2);
    expect_ack("R6 urgent revoke", 4'b0000);
    rq[1] = 1'b0;
    step(3);
    expect_ack("R6 urgent grant", 4'b0001);
    rq[1] = 1'b1;
    step(6);
    expect_ack("R12 urgency kept", 4'b0001);
    rq[0] = 1'b0;
    step(2);
    expect_ack("R12 after ref", 4'b0010);
    rq = '0; step(3);

    prev = '0;
    for (int c = 0; c < 3000; c++) begin
      step(1);
      a = acks;
      checks++;
      if ($countones(a) > 1) begin
        errors++;
        $display("FAIL R2 ack=%b expected=onehot0", a);
      end
      rise = a & ~prev;
      if (rise != '0) begin
        checks++;
        if (a !== best_of(rq)) begin
          errors++;
          $display("FAIL R4 ack=%b expected=%b req=%b", a, best_of(rq), rq);
        end
      end
      for (int i = 0; i < 4; i++) begin
        if (rq[i]) begin
          if (prev[i] && !a[i]) rq[i] = 1'b0;
          else if (a[i] && $urandom_range(0, 7) == 0) rq[i] = 1'b0;
        end else if ($urandom_range(0, 5) == 0) begin
          rq[i] = 1'b1;
        end
      end
      prev = a;
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule